// File: doc/BRIEF.md
# Dual-Mode L2 Address Hash

This block reduces a 64-bit forwarding lookup key, formed from a station address and a filtering or VLAN identifier, to a 12-bit bucket number for a hashed MAC forwarding table. A mode input selects one of two XOR folds. In the first fold, twelve-bit chunks of the key are XORed together. In the second fold, the key is cut into 6-bit slices, and two independent XOR groups of interleaved slices form the upper and lower halves of the result.

Each bucket holds four entries. The block therefore also forms the full table row number by placing a 2-bit slot number below the bucket number. Key, mode and slot are all taken in the cycle in which `keyValid` is high. The bucket number, the row number and a valid strobe appear on registered outputs one clock later. The table memory and any overflow storage sit outside the block.

Top module: `l2dual_hash`

## Requirements
- R1: While `rstN` is low, `outValid`, `hash` and `rowIndex` are all zero.
- R2: `outValid` is high in the cycle after a cycle with `keyValid` high, and low in the cycle after a cycle with `keyValid` low. A new key may be accepted every cycle.
- R3: With `modeSel`=1, `hash[11:6]` is the XOR of `key[11:6]`, `key[17:12]`, `key[35:30]`, `key[41:36]`, `key[59:54]`, and `key[63:60]` zero-extended to 6 bits.
- R4: With `modeSel`=1, `hash[5:0]` is the XOR of `key[5:0]`, `key[23:18]`, `key[29:24]`, `key[47:42]` and `key[53:48]`.
- R5: With `modeSel`=0, `hash` is the XOR of `key[11:0]`, `key[23:12]`, `key[35:24]`, `key[47:36]`, the value `{key[53:48], key[59:54]}`, and `key[63:60]` zero-extended to 12 bits.
- R6: `rowIndex[13:2]` equals the registered `hash`, and `rowIndex[1:0]` equals the `slot` taken with the key.
- R7: `modeSel` is sampled in the same cycle as the key, so a change of `modeSel` after that cycle leaves the registered result unchanged.
- R8: In a cycle with `keyValid` low, `hash` and `rowIndex` keep their values, whatever `key`, `modeSel` and `slot` carry.
- R9: The all-zero key hashes to 0x000 in both modes. The all-ones key hashes to 0xFF0 with `modeSel`=0 and to 0xC3F with `modeSel`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyValid | input | 1 | Key, mode and slot are valid this cycle |
| key | input | 64 | Lookup key |
| modeSel | input | 1 | 1: interleaved 6-bit fold, 0: 12-bit chunk fold |
| slot | input | 2 | Entry position inside the bucket |
| hash | output | 12 | Registered bucket number |
| rowIndex | output | 14 | Registered table row number `{hash, slot}` |
| outValid | output | 1 | Result registers were loaded in the previous cycle |

## Verification
Single-bit keys are placed at the slice edges 0, 6, 48, 54, 60 and 63. A design that routed a slice into the wrong half, or that failed to swap the two 6-bit halves of the 48..59 chunk, would put the bit at the wrong hash position. The all-ones key in both modes catches a top slice that is not zero-extended, because such a slice leaks ones into bits the reference leaves clear. Further directed cases do the following:
- Flip `modeSel` right after capture, to expose a mode that is read late.
- Drive garbage with `keyValid` low, to expose registers that load without the strobe.
- Sweep all four slot values, to catch a misplaced slot field.

// File: rtl/l2hash_pkg.sv
package l2hash_pkg;
  localparam int KEY_W   = 64;
  localparam int SLICE_W = 6;
  localparam int HASH_W  = 2 * SLICE_W;
  localparam int SLOT_W  = 2;
  localparam int ROW_W   = HASH_W + SLOT_W;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;
  } hashCtrl_t;
endpackage

// File: rtl/l2hash_fold.sv
module l2hash_fold
  import l2hash_pkg::*;
#(
  parameter int KW = KEY_W,
  parameter int SW = SLICE_W
) (
  input  logic [KW-1:0]   key,
  input  logic            modeSel,
  output logic [2*SW-1:0] hashComb
);
  localparam int NUM_SLICE = (KW + SW - 1) / SW;
  localparam int PAD_W     = NUM_SLICE * SW;
  localparam int NUM_PAIR  = NUM_SLICE / 2;
  localparam int HW        = 2 * SW;

  logic [PAD_W-1:0] keyPad;
  logic [SW-1:0]    slice [NUM_SLICE];
  logic [HW-1:0]    pairVal [NUM_PAIR];
  logic [SW-1:0]    upperFold;
  logic [SW-1:0]    lowerFold;
  logic [HW-1:0]    chunkFold;

  assign keyPad = {{(PAD_W - KW){1'b0}}, key};

  for (genvar s = 0; s < NUM_SLICE; s++) begin : g_slice
    assign slice[s] = keyPad[s*SW +: SW];
  end

  // 12-bit chunks; the topmost full chunk has its halves swapped
  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    if (p == NUM_PAIR - 1) begin : g_swap
      assign pairVal[p] = {slice[2*p], slice[2*p+1]};
    end else begin : g_plain
      assign pairVal[p] = {slice[2*p+1], slice[2*p]};
    end
  end

  // interleaved groups: slices with index mod 4 in {1,2} go to the upper half
  always_comb begin
    upperFold = '0;
    lowerFold = '0;
    for (int s = 0; s < NUM_SLICE; s++) begin
      if ((s % 4 == 1) || (s % 4 == 2)) upperFold = upperFold ^ slice[s];
      else                              lowerFold = lowerFold ^ slice[s];
    end
  end

  always_comb begin
    chunkFold = '0;
    for (int p = 0; p < NUM_PAIR; p++) chunkFold = chunkFold ^ pairVal[p];
    if (NUM_SLICE % 2 == 1)
      chunkFold = chunkFold ^ {{SW{1'b0}}, slice[NUM_SLICE-1]};
  end

  assign hashComb = modeSel ? {upperFold, lowerFold} : chunkFold;
endmodule

// File: rtl/l2hash_ctrl.sv
module l2hash_ctrl
  import l2hash_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      keyValid,
  output hashCtrl_t ctrl,
  output logic      outValid
);
  logic validQ;

  always_comb ctrl.loadEn = keyValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= keyValid;
  end

  assign outValid = validQ;
endmodule

// File: rtl/l2hash_datapath.sv
module l2hash_datapath
  import l2hash_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hashCtrl_t         ctrl,
  input  logic [KEY_W-1:0]  key,
  input  logic              modeSel,
  input  logic [SLOT_W-1:0] slot,
  output logic [HASH_W-1:0] hash,
  output logic [ROW_W-1:0]  rowIndex
);
  logic [HASH_W-1:0] hashComb;
  logic [HASH_W-1:0] hashQ;
  logic [SLOT_W-1:0] slotQ;

  l2hash_fold #(.KW(KEY_W), .SW(SLICE_W)) u_fold (
    .key      (key),
    .modeSel  (modeSel),
    .hashComb (hashComb)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hashQ <= '0;
      slotQ <= '0;
    end else if (ctrl.loadEn) begin
      hashQ <= hashComb;
      slotQ <= slot;
    end
  end

  assign hash     = hashQ;
  assign rowIndex = {hashQ, slotQ};
endmodule

// File: rtl/l2dual_hash.sv
module l2dual_hash
  import l2hash_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              keyValid,
  input  logic [KEY_W-1:0]  key,
  input  logic              modeSel,
  input  logic [SLOT_W-1:0] slot,
  output logic [HASH_W-1:0] hash,
  output logic [ROW_W-1:0]  rowIndex,
  output logic              outValid
);
  hashCtrl_t ctrl;

  l2hash_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .keyValid (keyValid),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  l2hash_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .key      (key),
    .modeSel  (modeSel),
    .slot     (slot),
    .hash     (hash),
    .rowIndex (rowIndex)
  );
endmodule

// File: rtl/l2dual_hash_checker.sv
module l2dual_hash_checker
  import l2hash_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              keyValid,
  input logic [KEY_W-1:0]  key,
  input logic [SLOT_W-1:0] slot,
  input logic [HASH_W-1:0] hash,
  input logic [ROW_W-1:0]  rowIndex,
  input logic              outValid
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |-> (!outValid && hash == '0 && rowIndex == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> outValid);

  a_r2_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !keyValid |=> !outValid);

  a_r6_slot_carried: assert property (@(posedge clk) disable iff (!rstN)
    keyValid |=> rowIndex[SLOT_W-1:0] == $past(slot));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !keyValid |=> ($stable(hash) && $stable(rowIndex)));

  a_r9_zero_key: assert property (@(posedge clk) disable iff (!rstN)
    (keyValid && key == '0) |=> hash == '0);
endmodule

bind l2dual_hash l2dual_hash_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .keyValid (keyValid),
  .key      (key),
  .slot     (slot),
  .hash     (hash),
  .rowIndex (rowIndex),
  .outValid (outValid)
);

// File: tb/l2dual_hash_bench.sv
module l2dual_hash_bench;
  typedef struct packed {
    logic [63:0] key;
    logic        mode;
    logic [1:0]  slot;
    logic [11:0] expHash;
  } vec_t;

  localparam int NUM_VEC = 16;
  localparam vec_t VECS [NUM_VEC] = '{
    '{64'h0,                  1'b0, 2'd0, 12'h000},  // R9
    '{64'h0,                  1'b1, 2'd1, 12'h000},  // R9
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 2'd2, 12'hFF0}, // R9
    '{64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'd3, 12'hC3F}, // R9
    '{64'h1000_0000_0000_0000, 1'b1, 2'd0, 12'h040}, // R3 bit 60
    '{64'h1000_0000_0000_0000, 1'b0, 2'd0, 12'h001}, // R5
    '{64'h0040_0000_0000_0000, 1'b1, 2'd1, 12'h040}, // R3 bit 54
    '{64'h0040_0000_0000_0000, 1'b0, 2'd1, 12'h001}, // R5 swap
    '{64'h0001_0000_0000_0000, 1'b1, 2'd2, 12'h001}, // R4 bit 48
    '{64'h0001_0000_0000_0000, 1'b0, 2'd2, 12'h040}, // R5 swap
    '{64'h0000_0000_0000_0001, 1'b1, 2'd3, 12'h001}, // R4 bit 0
    '{64'h0000_0000_0000_0001, 1'b0, 2'd3, 12'h001}, // R5
    '{64'h0000_0000_0000_0040, 1'b1, 2'd0, 12'h040}, // R3 bit 6
    '{64'h0000_0000_0000_0040, 1'b0, 2'd1, 12'h040}, // R5
    '{64'h8000_0000_0000_0000, 1'b1, 2'd2, 12'h200}, // R3 bit 63
    '{64'h8000_0000_0000_0000, 1'b0, 2'd3, 12'h008}  // R5 bit 63
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        keyValid = 1'b0;
  logic [63:0] key = '0;
  logic        modeSel = 1'b0;
  logic [1:0]  slot = '0;
  logic [11:0] hash;
  logic [13:0] rowIndex;
  logic        outValid;

  int checks = 0;
  int fails = 0;
  logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

  always #2 clk = ~clk;

  l2dual_hash u_l2dual_hash (
    .clk(clk), .rstN(rstN), .keyValid(keyValid), .key(key),
    .modeSel(modeSel), .slot(slot), .hash(hash), .rowIndex(rowIndex),
    .outValid(outValid)
  );

  function automatic logic [11:0] refHash(input logic [63:0] k, input logic m);
    logic [5:0] hi;
    logic [5:0] lo;
    logic [11:0] f;
    if (m) begin
      hi = {2'b00, k[63:60]} ^ k[59:54] ^ k[41:36] ^ k[35:30] ^ k[17:12] ^ k[11:6];
      lo = k[53:48] ^ k[47:42] ^ k[29:24] ^ k[23:18] ^ k[5:0];
      return {hi, lo};
    end
    f = {8'h00, k[63:60]} ^ {k[53:48], k[59:54]} ^ k[47:36] ^ k[35:24]
        ^ k[23:12] ^ k[11:0];
    return f;
  endfunction

  function automatic logic [63:0] nextRand(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one key, then sample results one negedge later
  task automatic pushKey(input logic [63:0] k, input logic m, input logic [1:0] s);
    @(negedge clk);
    keyValid = 1'b1; key = k; modeSel = m; slot = s;
    @(negedge clk);
    keyValid = 1'b0;
  endtask

  initial begin : watchdog
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [11:0] h;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 outValid", 32'(outValid), 0);
    check("R1 hash", 32'(hash), 0);
    check("R1 rowIndex", 32'(rowIndex), 0);
    rstN = 1'b1;

    // vector table: R3 R4 R5 R6 R9
    for (int i = 0; i < NUM_VEC; i++) begin
      pushKey(VECS[i].key, VECS[i].mode, VECS[i].slot);
      check("R3/R4/R5/R9 vector hash", 32'(hash), 32'(VECS[i].expHash));
      check("R6 vector row", 32'(rowIndex), 32'({VECS[i].expHash, VECS[i].slot}));
      check("R2 vector valid", 32'(outValid), 1);
    end

    // random keys, both modes
    for (int i = 0; i < 200; i++) begin
      lfsr = nextRand(lfsr);
      pushKey(lfsr, i[0], i[2:1]);
      h = refHash(lfsr, i[0]);
      check(i[0] ? "R3/R4 random" : "R5 random", 32'(hash), 32'(h));
      check("R6 random row", 32'(rowIndex), 32'({h, i[2:1]}));
    end

    // R2 back-to-back acceptance
    @(negedge clk);
    keyValid = 1'b1; key = 64'h0123_4567_89AB_CDEF; modeSel = 1'b1; slot = 2'd1;
    @(negedge clk);
    check("R2 b2b first", 32'(hash), 32'(refHash(64'h0123_4567_89AB_CDEF, 1'b1)));
    check("R2 b2b valid", 32'(outValid), 1);
    key = 64'hFEDC_BA98_7654_3210; modeSel = 1'b0; slot = 2'd2;
    @(negedge clk);
    keyValid = 1'b0;
    check("R2 b2b second", 32'(hash), 32'(refHash(64'hFEDC_BA98_7654_3210, 1'b0)));
    @(negedge clk);
    check("R2 valid drops", 32'(outValid), 0);

    // R7 mode change after capture has no effect
    @(negedge clk);
    keyValid = 1'b1; key = 64'hA5A5_0F0F_3C3C_9999; modeSel = 1'b1; slot = 2'd3;
    @(negedge clk);
    keyValid = 1'b0; modeSel = 1'b0;
    @(negedge clk);
    check("R7 mode held", 32'(hash), 32'(refHash(64'hA5A5_0F0F_3C3C_9999, 1'b1)));

    // R8 idle inputs ignored
    key = 64'h1111_2222_3333_4444; slot = 2'd0; modeSel = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 hash held", 32'(hash), 32'(refHash(64'hA5A5_0F0F_3C3C_9999, 1'b1)));
    check("R8 row held", 32'(rowIndex),
          32'({refHash(64'hA5A5_0F0F_3C3C_9999, 1'b1), 2'd3}));
    check("R8 valid low", 32'(outValid), 0);

    // R1 reset mid-run
    rstN = 1'b0;
    #1;
    check("R1 reset hash", 32'(hash), 0);
    check("R1 reset valid", 32'(outValid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule